// File: doc/BRIEF.md
# Voltage/Frequency Operating-Point Sequencer

This block moves a processor core between performance levels. Each level index selects a supply-regulator code and a clock-synthesizer code from a fixed computed mapping. When a new level is requested, the sequencer changes the two codes one at a time. It waits for a handshake from the regulator or the clock synthesizer before each second step, so the clock never runs faster than the present supply can support.

The block raises the voltage before the frequency when speeding up. It lowers the frequency before the voltage when slowing down. A request that arrives during a transition is parked in a single slot, and the newest one wins. It is acted on once the running transition finishes.

Every handshake wait has a cycle limit. On expiry the block raises a sticky error flag and parks at the last safe pair of codes. It stays there until reset.

Top module: `opp_sequencer`

## Requirements
- R1: After reset `vreg_code`, `pll_code` and `cur_level` are 0, and `busy` and `err` are 0.
- R2: A level L drives `vreg_code` = L and `pll_code` = L*(FREQ_STEPS-1)/(LEVELS-1), which is also L with the default parameters. A requested level above LEVELS-1 is treated as LEVELS-1.
- R3: A request presented with `req_valid` in the cycle before rising edge A is stored at edge A. The first code change and `busy` appear after the next edge, edge B.
- R4: When moving to a higher level, `vreg_code` changes first and `pll_code` stays at its old value. `pll_code` rises only after a `vreg_done` pulse has been sampled. With the default mapping, `pll_code` never exceeds `vreg_code`.
- R5: When moving to a lower level, `pll_code` changes first and `vreg_code` stays at its old value. `vreg_code` falls only after a `pll_done` pulse has been sampled.
- R6: `cur_level` takes the new level, and `busy` falls, at the edge that samples the second handshake pulse. `cur_level` never changes without a transition in progress.
- R7: A request equal to `cur_level` completes without any code change, and `busy` never rises.
- R8: Requests made while a transition runs are held in one slot, and the newest overwrites older ones. The held request is started after the running transition completes.
- R9: If no handshake pulse arrives within TIMEOUT_CYC cycles of a wait starting, `err` rises and stays high, and `busy` falls. Both codes keep their values, and `cur_level` keeps the last completed level.
- R10: While `err` is high, requests are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_level | input | REQ_W | Requested performance level |
| vreg_code | output | LVL_W | Supply-regulator setting |
| vreg_done | input | 1 | One-cycle pulse: regulator settled at the code |
| pll_code | output | FC_W | Clock-synthesizer setting |
| pll_done | input | 1 | One-cycle pulse: synthesizer locked at the code |
| busy | output | 1 | Transition in progress |
| cur_level | output | LVL_W | Last completed level |
| err | output | 1 | Sticky handshake-timeout flag |

## Verification
The ordering properties assume the two handshake inputs are single-cycle pulses. They also assume each pulse arrives some cycles after the matching code last changed, never as a level held across a code change. The bench models both the regulator and the synthesizer as delay counters that restart whenever their code moves. Each counter emits exactly one pulse when it expires, so stale or repeated acknowledgements never occur. For the timeout case, the regulator model is muted and simply never pulses.

// File: rtl/opp_pkg.sv
// Package: shared state encoding for the operating-point sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package opp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transition, waiting for a stored request
        ST_UP_V,   // raising: voltage issued, waiting for regulator
        ST_UP_F,   // raising: frequency issued, waiting for lock
        ST_DN_F,   // lowering: frequency issued, waiting for lock
        ST_DN_V,   // lowering: voltage issued, waiting for regulator
        ST_FAULT   // handshake timed out, parked until reset
    } seq_state_t;

endpackage

// File: rtl/opp_table.sv
// Module: maps a level index to a regulator code and a frequency code.
// Assumes: level is already saturated to LEVELS-1; the mapping is monotonic,
// so a higher level never yields a lower code.
module opp_table #(
    parameter int LEVELS     = 16,
    parameter int FREQ_STEPS = 16,
    parameter int LVL_W      = $clog2(LEVELS),
    parameter int FC_W       = $clog2(FREQ_STEPS)
) (
    input  logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] vcode,
    output logic [FC_W-1:0]  fcode
);

    localparam int LAST_LVL  = LEVELS - 1;
    localparam int LAST_FREQ = FREQ_STEPS - 1;

    int scaled;

    // Purpose: linear scaling of level onto the frequency step range.
    always_comb begin
        scaled = (int'(level) * LAST_FREQ) / LAST_LVL;
        vcode  = level;
        fcode  = FC_W'(scaled);
    end

endmodule

// File: rtl/opp_wait_timer.sv
// Module: counts cycles spent waiting for a handshake and flags expiry.
// Assumes: clr is held while no wait is active and pulses whenever a wait
// is satisfied, so each wait starts counting from zero.
module opp_wait_timer #(
    parameter int TIMEOUT_CYC = 30000,
    parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic expired
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = run && (cnt_q == LIMIT);

    // Purpose: advance the wait counter, restarting it on each new wait.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/opp_ctrl.sv
// Module: transition state machine with a one-slot request store.
// Assumes: vreg_done/pll_done are single-cycle pulses that arrive only after
// the matching code changed; map_vcode/map_fcode are combinational from map_lvl.
module opp_ctrl
    import opp_pkg::*;
#(
    parameter int LEVELS = 16,
    parameter int REQ_W  = 5,
    parameter int LVL_W  = $clog2(LEVELS),
    parameter int FC_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_level,
    input  logic             vreg_done,
    input  logic             pll_done,
    input  logic             expired,
    input  logic [LVL_W-1:0] map_vcode,
    input  logic [FC_W-1:0]  map_fcode,
    output logic [LVL_W-1:0] map_lvl,
    output logic [LVL_W-1:0] vreg_code,
    output logic [FC_W-1:0]  pll_code,
    output logic             busy,
    output logic [LVL_W-1:0] cur_level,
    output logic             err,
    output logic             wait_run,
    output logic             wait_clr
);

    localparam logic [REQ_W-1:0] TOP_REQ = REQ_W'(LEVELS - 1);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    seq_state_t       state_q;
    logic             pend_v;
    logic [LVL_W-1:0] pend_lvl;
    logic [LVL_W-1:0] tgt_q;
    logic [LVL_W-1:0] sat_lvl;
    logic             dispatch;
    logic             ack_taken;

    // Purpose: clamp the incoming request to the highest level.
    always_comb begin
        sat_lvl = (req_level > TOP_REQ) ? TOP_LVL : req_level[LVL_W-1:0];
    end

    // Purpose: decode wait status and handshake acceptance.
    always_comb begin
        busy      = (state_q == ST_UP_V) || (state_q == ST_UP_F) ||
                    (state_q == ST_DN_F) || (state_q == ST_DN_V);
        ack_taken = (((state_q == ST_UP_V) || (state_q == ST_DN_V)) && vreg_done) ||
                    (((state_q == ST_UP_F) || (state_q == ST_DN_F)) && pll_done);
        dispatch  = (state_q == ST_IDLE) && pend_v;
        map_lvl   = (state_q == ST_IDLE) ? pend_lvl : tgt_q;
        wait_run  = busy;
        wait_clr  = !busy || ack_taken;
    end

    // Purpose: one-slot request store, newest request wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_lvl <= '0;
        end else if (req_valid && (state_q != ST_FAULT)) begin
            pend_v   <= 1'b1;
            pend_lvl <= sat_lvl;
        end else if (dispatch) begin
            pend_v   <= 1'b0;
        end
    end

    // Purpose: sequence the two code changes around the handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tgt_q     <= '0;
            cur_level <= '0;
            vreg_code <= '0;
            pll_code  <= '0;
            err       <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (pend_v && (pend_lvl > cur_level)) begin
                        tgt_q     <= pend_lvl;
                        vreg_code <= map_vcode;
                        state_q   <= ST_UP_V;
                    end else if (pend_v && (pend_lvl < cur_level)) begin
                        tgt_q     <= pend_lvl;
                        pll_code  <= map_fcode;
                        state_q   <= ST_DN_F;
                    end
                end
                ST_UP_V: begin
                    if (vreg_done) begin
                        pll_code <= map_fcode;
                        state_q  <= ST_UP_F;
                    end else if (expired) begin
                        err     <= 1'b1;
                        state_q <= ST_FAULT;
                    end
                end
                ST_UP_F: begin
                    if (pll_done) begin
                        cur_level <= tgt_q;
                        state_q   <= ST_IDLE;
                    end else if (expired) begin
                        err     <= 1'b1;
                        state_q <= ST_FAULT;
                    end
                end
                ST_DN_F: begin
                    if (pll_done) begin
                        vreg_code <= map_vcode;
                        state_q   <= ST_DN_V;
                    end else if (expired) begin
                        err     <= 1'b1;
                        state_q <= ST_FAULT;
                    end
                end
                ST_DN_V: begin
                    if (vreg_done) begin
                        cur_level <= tgt_q;
                        state_q   <= ST_IDLE;
                    end else if (expired) begin
                        err     <= 1'b1;
                        state_q <= ST_FAULT;
                    end
                end
                default: begin
                    state_q <= ST_FAULT;
                end
            endcase
        end
    end

endmodule

// File: rtl/opp_sequencer.sv
// Module: top of the operating-point sequencer; ties the mapping, the state
// machine and the wait timer together.
// Assumes: a single clock domain; handshake inputs already synchronised.
module opp_sequencer #(
    parameter int LEVELS      = 16,
    parameter int FREQ_STEPS  = 16,
    parameter int REQ_W       = 5,
    parameter int TIMEOUT_CYC = 30000,
    parameter int LVL_W       = $clog2(LEVELS),
    parameter int FC_W        = $clog2(FREQ_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_level,
    output logic [LVL_W-1:0] vreg_code,
    input  logic             vreg_done,
    output logic [FC_W-1:0]  pll_code,
    input  logic             pll_done,
    output logic             busy,
    output logic [LVL_W-1:0] cur_level,
    output logic             err
);

    logic [LVL_W-1:0] map_lvl;
    logic [LVL_W-1:0] map_vcode;
    logic [FC_W-1:0]  map_fcode;
    logic             wait_run;
    logic             wait_clr;
    logic             expired;

    opp_table #(
        .LEVELS(LEVELS), .FREQ_STEPS(FREQ_STEPS), .LVL_W(LVL_W), .FC_W(FC_W)
    ) u_table (
        .level(map_lvl), .vcode(map_vcode), .fcode(map_fcode)
    );

    opp_wait_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(wait_run), .clr(wait_clr), .expired(expired)
    );

    opp_ctrl #(
        .LEVELS(LEVELS), .REQ_W(REQ_W), .LVL_W(LVL_W), .FC_W(FC_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_level(req_level),
        .vreg_done(vreg_done), .pll_done(pll_done), .expired(expired),
        .map_vcode(map_vcode), .map_fcode(map_fcode), .map_lvl(map_lvl),
        .vreg_code(vreg_code), .pll_code(pll_code),
        .busy(busy), .cur_level(cur_level), .err(err),
        .wait_run(wait_run), .wait_clr(wait_clr)
    );

endmodule

// File: rtl/opp_sequencer_checker.sv
// Module: protocol and ordering properties of the sequencer, bound to the top.
// Assumes: handshake inputs are single-cycle pulses following a code change.
module opp_sequencer_checker #(
    parameter int LVL_W = 4,
    parameter int FC_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] vreg_code,
    input logic             vreg_done,
    input logic [FC_W-1:0]  pll_code,
    input logic             pll_done,
    input logic             busy,
    input logic [LVL_W-1:0] cur_level,
    input logic             err
);

    // Frequency may rise only right after the regulator confirmed.
    assert_freq_up_after_vdone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_code > $past(pll_code)) |-> $past(vreg_done));

    // Voltage may fall only right after the synthesizer confirmed.
    assert_volt_down_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_code < $past(vreg_code)) |-> $past(pll_done));

    // The reported level moves only at the end of a running transition.
    assert_level_moves_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level != $past(cur_level)) |-> $past(busy));

    // A timeout is sticky.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // A faulted sequencer is not busy.
    assert_err_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // Once faulted, both codes and the level are frozen.
    assert_fault_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && $past(err)) |-> ($stable(vreg_code) && $stable(pll_code) && $stable(cur_level)));

endmodule

bind opp_sequencer opp_sequencer_checker #(.LVL_W(LVL_W), .FC_W(FC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vreg_code(vreg_code), .vreg_done(vreg_done),
    .pll_code(pll_code), .pll_done(pll_done), .busy(busy),
    .cur_level(cur_level), .err(err)
);

// File: tb/opp_sequencer_bench.sv
// Bench: directed scenarios with behavioural regulator and synthesizer models.
module opp_sequencer_bench;

    localparam int LEVELS  = 16;
    localparam int REQ_W   = 5;
    localparam int TMO     = 40;
    localparam int DLY     = 6;
    localparam int LVL_W   = 4;
    localparam int FC_W    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [REQ_W-1:0] req_level = '0;
    logic [LVL_W-1:0] vreg_code;
    logic             vreg_done = 1'b0;
    logic [FC_W-1:0]  pll_code;
    logic             pll_done = 1'b0;
    logic             busy;
    logic [LVL_W-1:0] cur_level;
    logic             err;

    int checks = 0;
    int fails  = 0;
    int v_pulses = 0;
    int p_pulses = 0;
    int unsafe = 0;
    bit v_mute = 1'b0;
    int v_cnt = 0;
    int p_cnt = 0;
    logic [LVL_W-1:0] v_last = '0;
    logic [FC_W-1:0]  p_last = '0;

    always #5 clk = ~clk;

    opp_sequencer #(
        .LEVELS(LEVELS), .FREQ_STEPS(16), .REQ_W(REQ_W), .TIMEOUT_CYC(TMO)
    ) u_opp_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .vreg_code(vreg_code), .vreg_done(vreg_done), .pll_code(pll_code),
        .pll_done(pll_done), .busy(busy), .cur_level(cur_level), .err(err)
    );

    // Regulator and synthesizer models: one pulse DLY cycles after a code move.
    always @(negedge clk) begin
        vreg_done = 1'b0;
        pll_done  = 1'b0;
        if (!rst_n) begin
            v_last = '0; p_last = '0; v_cnt = 0; p_cnt = 0;
        end else begin
            if (vreg_code != v_last) begin
                v_last = vreg_code; v_cnt = DLY;
            end else if (v_cnt > 0) begin
                v_cnt = v_cnt - 1;
                if (v_cnt == 0 && !v_mute) begin
                    vreg_done = 1'b1; v_pulses = v_pulses + 1;
                end
            end
            if (pll_code != p_last) begin
                p_last = pll_code; p_cnt = DLY;
            end else if (p_cnt > 0) begin
                p_cnt = p_cnt - 1;
                if (p_cnt == 0) begin
                    pll_done = 1'b1; p_pulses = p_pulses + 1;
                end
            end
            if (pll_code > vreg_code) unsafe = unsafe + 1;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300 && busy; i++) step();
    endtask

    // Reset and its resulting output state (R1).
    task automatic t_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        v_mute = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 vreg_code", int'(vreg_code), 0);
        check("R1 pll_code", int'(pll_code), 0);
        check("R1 cur_level", int'(cur_level), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 err", int'(err), 0);
    endtask

    // One complete move with ordering and timing checks (R2..R6).
    task automatic t_move(input int req, input int lvl);
        int old = int'(cur_level);
        int vp, pp;
        req_valid = 1'b1;
        req_level = REQ_W'(req);
        step();
        req_valid = 1'b0;
        check("R3 not busy after first edge", int'(busy), 0);
        vp = v_pulses;
        pp = p_pulses;
        step();
        check("R3 busy after second edge", int'(busy), 1);
        if (lvl > old) begin
            check("R4 voltage first", int'(vreg_code), lvl);
            check("R4 freq held", int'(pll_code), old);
            for (int i = 0; i < 100 && int'(pll_code) == old; i++) step();
            check("R4 freq after regulator pulse", int'(v_pulses > vp), 1);
        end else begin
            check("R5 freq first", int'(pll_code), lvl);
            check("R5 voltage held", int'(vreg_code), old);
            for (int i = 0; i < 100 && int'(vreg_code) == old; i++) step();
            check("R5 voltage after lock pulse", int'(p_pulses > pp), 1);
        end
        wait_idle();
        check("R6 cur_level", int'(cur_level), lvl);
        check("R2 vreg_code", int'(vreg_code), lvl);
        check("R2 pll_code", int'(pll_code), lvl);
    endtask

    // Request equal to the present level (R7).
    task automatic t_equal();
        int lvl = int'(cur_level);
        int saw_busy = 0;
        req_valid = 1'b1;
        req_level = REQ_W'(lvl);
        step();
        req_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step();
            if (busy) saw_busy = 1;
        end
        check("R7 busy never rose", saw_busy, 0);
        check("R7 vreg_code unchanged", int'(vreg_code), lvl);
        check("R7 pll_code unchanged", int'(pll_code), lvl);
    endtask

    // Requests while busy: held, newest wins (R8).
    task automatic t_queue();
        int saw4 = 0;
        req_valid = 1'b1;
        req_level = REQ_W'(4);
        step();
        req_level = REQ_W'(9);
        step();
        req_level = REQ_W'(1);
        step();
        req_valid = 1'b0;
        for (int i = 0; i < 400 && !(cur_level == 1 && !busy); i++) begin
            step();
            if (cur_level == 4) saw4 = 1;
        end
        check("R8 first request completed", saw4, 1);
        check("R8 newest request applied", int'(cur_level), 1);
        check("R8 pll_code", int'(pll_code), 1);
        check("R8 vreg_code", int'(vreg_code), 1);
    endtask

    // Silent regulator leads to timeout and a frozen fault (R9, R10).
    task automatic t_timeout();
        v_mute = 1'b1;
        req_valid = 1'b1;
        req_level = REQ_W'(8);
        step();
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !err; i++) step();
        check("R9 err raised", int'(err), 1);
        check("R9 busy dropped", int'(busy), 0);
        check("R9 cur_level kept", int'(cur_level), 1);
        check("R9 freq held at safe value", int'(pll_code), 1);
        check("R9 voltage kept", int'(vreg_code), 8);
        v_mute = 1'b0;
        req_valid = 1'b1;
        req_level = REQ_W'(3);
        step();
        req_valid = 1'b0;
        repeat (20) step();
        check("R10 request ignored, vreg_code", int'(vreg_code), 8);
        check("R10 request ignored, pll_code", int'(pll_code), 1);
        check("R10 request ignored, busy", int'(busy), 0);
        check("R10 err still set", int'(err), 1);
    endtask

    initial begin
        t_reset();
        t_move(5, 5);
        t_move(2, 2);
        t_equal();
        t_move(31, 15);
        t_queue();
        check("R4 frequency never above voltage", unsafe, 0);
        t_timeout();
        t_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule